// File: doc/BRIEF.md
# Coarse-fine link delay meter

This block measures the round-trip delay of a serial link. It runs in a word clock that is isochronous with the transmitter. A start pulse marks the word cycle in which a marker code group is sent. From that cycle the block counts whole word periods of 6.4 ns. It stops when the receive path delivers the marker inside an aligned 20-bit word.

The delay is then refined to one-bit resolution. The bit-slip offset reported by the aligner is added at 320 ps per bit. One more step is added when the marker is found in the later 10-bit half of the word.

The result is available in three forms: the coarse word count, the fine bit count, and a total in picoseconds. A one-cycle done pulse signals that the result is ready. If the link never returns the marker, the coarse counter saturates and a timeout flag is raised.

Top module: `pdm_delay_meter`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `coarse_o`, `fine_o`, `delay_ps_o`, `done_o` and `timeout_o` are all zero, and no measurement is armed.
- R2: A clock edge that samples `start_i` high arms a measurement. If the marker is first accepted k edges later (k >= 1), `coarse_o` reports k.
- R3: The marker is the 10-bit group 1110101000 or its complement 0001010111. Slot 0 is `rx_word_i[9:0]` and slot 1 is `rx_word_i[19:10]`. A match in either slot counts as a marker, and slot 0 wins when both slots match.
- R4: `fine_o` is `slip_ofs_i` sampled with the marker, plus 10 when the marker was in slot 1. `coarse_o` and `fine_o` change in the cycle after the marker edge.
- R5: `delay_ps_o` equals `coarse_o`*6400 + `fine_o`*320. It becomes valid one cycle after `coarse_o` and `fine_o`, in the same cycle that `done_o` is high.
- R6: A marker is ignored, and counting goes on, when `rx_aligned_i` is low. A marker is also ignored when no measurement is armed; the outputs then keep their values.
- R7: `done_o` is high for exactly one cycle per completed measurement. Results hold until the next start, which clears them to zero.
- R8: If the count reaches 131071 and the next edge sees no accepted marker, `timeout_o` rises and the measurement disarms. `done_o` stays low and `coarse_o` stays zero. The next start clears `timeout_o`.
- R9: A start while a measurement is armed restarts the count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Marker-sent pulse, arms a measurement |
| rx_word_i | input | 20 | Aligned receive word, two 10-bit slots |
| rx_aligned_i | input | 1 | Receive word alignment is valid |
| slip_ofs_i | input | 5 | Bit-slip offset of the aligner, 0 to 19 |
| coarse_o | output | 17 | Whole word cycles from start to marker |
| fine_o | output | 5 | Bit-time part of the delay |
| delay_ps_o | output | 32 | Total delay in picoseconds |
| done_o | output | 1 | One-cycle result-ready pulse |
| timeout_o | output | 1 | Counter saturated without a marker |

## Verification
The assertions assume that `slip_ofs_i` stays within 0 to 19, which is the range of a 20-bit aligner. The fine sum therefore never exceeds 29 and always fits in five bits. Every vector the stimulus applies keeps the offset inside that range.

The stimulus changes inputs only between edges. A marker word is held for exactly one cycle and is surrounded by idle pairs that match neither marker pattern. This keeps each accepted marker tied to a single counted edge.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    localparam int WORD_W  = 20;
    localparam int SLOT_W  = 10;
    localparam int NSLOT   = WORD_W / SLOT_W;
    localparam int SLOT_IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int CNT_W   = 17;
    localparam int OFS_W   = 5;
    localparam int FINE_W  = 5;
    localparam int RES_W   = 32;
    localparam int WORD_PS = 6400;
    localparam int BIT_PS  = 320;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // carrier-extend group, both running disparities
    localparam logic [SLOT_W-1:0] MARK_NEG = 10'b1110101000;
    localparam logic [SLOT_W-1:0] MARK_POS = 10'b0001010111;

    typedef struct packed {
        logic               hit;
        logic [SLOT_IW-1:0] slot;
    } mark_t;

    function automatic logic is_marker(input logic [SLOT_W-1:0] g);
        return (g == MARK_NEG) || (g == MARK_POS);
    endfunction
endpackage

// File: rtl/pdm_marker_detect.sv
module pdm_marker_detect
    import pdm_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              aligned_i,
    output mark_t             mark_o
);
    logic [NSLOT-1:0] match;

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign match[s] = is_marker(word_i[s*SLOT_W +: SLOT_W]);
        end
    endgenerate

    always_comb begin
        mark_o.hit  = aligned_i && (|match);
        mark_o.slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (match[s]) mark_o.slot = SLOT_IW'(s);
        end
    end
endmodule

// File: rtl/pdm_coarse_counter.sv
module pdm_coarse_counter
    import pdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             hit_i,
    output logic             capture_o,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            count_o   <= '0;
            timeout_o <= 1'b0;
        end else if (start_i) begin
            armed_q   <= 1'b1;
            count_o   <= CNT_W'(1);
            timeout_o <= 1'b0;
        end else if (armed_q) begin
            if (hit_i) begin
                armed_q <= 1'b0;
            end else if (count_o == CNT_MAX) begin
                armed_q   <= 1'b0;
                timeout_o <= 1'b1;
            end else begin
                count_o <= count_o + 1'b1;
            end
        end
    end

    assign capture_o = armed_q && hit_i && !start_i;

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !start_i && !hit_i && count_o != CNT_MAX)
        |=> (count_o == $past(count_o) + 1'b1));

    p_timeout_sat_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> ($past(count_o) == CNT_MAX && !$past(hit_i)));
endmodule

// File: rtl/pdm_delay_calc.sv
module pdm_delay_calc
    import pdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               capture_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [OFS_W-1:0]   ofs_i,
    input  logic [SLOT_IW-1:0] slot_i,
    output logic [CNT_W-1:0]   coarse_o,
    output logic [FINE_W-1:0]  fine_o,
    output logic [RES_W-1:0]   delay_o,
    output logic               done_o
);
    logic             pend_q;
    logic [FINE_W-1:0] fine_d;

    assign fine_d = FINE_W'(ofs_i) + FINE_W'(slot_i) * FINE_W'(SLOT_W);

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            coarse_o <= '0;
            fine_o   <= '0;
            delay_o  <= '0;
            pend_q   <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            pend_q <= capture_i;
            done_o <= pend_q;
            if (capture_i) begin
                coarse_o <= count_i;
                fine_o   <= fine_d;
            end
            if (pend_q) begin
                delay_o <= RES_W'(coarse_o) * RES_W'(WORD_PS)
                         + RES_W'(fine_o) * RES_W'(BIT_PS);
            end
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !capture_i) |=> ($stable(coarse_o) && $stable(fine_o)));

    p_total_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (delay_o == RES_W'(coarse_o) * RES_W'(WORD_PS)
                             + RES_W'(fine_o) * RES_W'(BIT_PS)));
endmodule

// File: rtl/pdm_delay_meter.sv
module pdm_delay_meter
    import pdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic              rx_aligned_i,
    input  logic [OFS_W-1:0]  slip_ofs_i,
    output logic [CNT_W-1:0]  coarse_o,
    output logic [FINE_W-1:0] fine_o,
    output logic [RES_W-1:0]  delay_ps_o,
    output logic              done_o,
    output logic              timeout_o
);
    mark_t            mark;
    logic             capture;
    logic [CNT_W-1:0] count;

    pdm_marker_detect u_detect (
        .word_i    (rx_word_i),
        .aligned_i (rx_aligned_i),
        .mark_o    (mark)
    );

    pdm_coarse_counter u_count (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .hit_i     (mark.hit),
        .capture_o (capture),
        .count_o   (count),
        .timeout_o (timeout_o)
    );

    pdm_delay_calc u_calc (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .capture_i (capture),
        .count_i   (count),
        .ofs_i     (slip_ofs_i),
        .slot_i    (mark.slot),
        .coarse_o  (coarse_o),
        .fine_o    (fine_o),
        .delay_o   (delay_ps_o),
        .done_o    (done_o)
    );

    p_ignore_unaligned_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_aligned_i |-> !capture);

    p_no_done_timeout_r8: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !done_o);
endmodule

// File: tb/pdm_delay_meter_test.sv
module pdm_delay_meter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [19:0] rx_word_i;
    logic        rx_aligned_i = 1'b1;
    logic [4:0]  slip_ofs_i = '0;
    logic [16:0] coarse_o;
    logic [4:0]  fine_o;
    logic [31:0] delay_ps_o;
    logic        done_o;
    logic        timeout_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [9:0] M_NEG = 10'b1110101000;
    localparam logic [9:0] M_POS = 10'b0001010111;
    localparam logic [9:0] IDL_K = 10'b0011111010;
    localparam logic [9:0] IDL_D = 10'b0110110101;
    localparam logic [19:0] IDLE = {IDL_D, IDL_K};

    // vectors: cycles k, offset, slot (2 = both slots), polarity
    localparam int NV = 9;
    localparam int VK [NV] = '{1, 2, 5, 3, 10, 100, 4, 7, 2};
    localparam int VO [NV] = '{0, 1, 3, 0, 19, 7, 12, 5, 19};
    localparam int VS [NV] = '{0, 0, 0, 1, 1, 0, 1, 2, 0};
    localparam int VP [NV] = '{0, 1, 0, 0, 1, 1, 0, 1, 0};

    initial rx_word_i = IDLE;

    pdm_delay_meter uut (
        .clk(clk), .rst(rst), .start_i(start_i), .rx_word_i(rx_word_i),
        .rx_aligned_i(rx_aligned_i), .slip_ofs_i(slip_ofs_i),
        .coarse_o(coarse_o), .fine_o(fine_o), .delay_ps_o(delay_ps_o),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [19:0] mark_word(input int slot, input int pol);
        logic [9:0] m;
        m = (pol != 0) ? M_POS : M_NEG;
        if (slot == 0) return {IDL_D, m};
        if (slot == 1) return {m, IDL_K};
        return {m, m};
    endfunction

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // marker sampled k edges after the start edge; returns at negedge after that edge
    task automatic send_marker(input int k, input int ofs, input int slot, input int pol);
        for (int i = 1; i < k; i++) @(negedge clk);
        rx_word_i  = mark_word(slot, pol);
        slip_ofs_i = 5'(ofs);
        @(negedge clk);
        rx_word_i  = IDLE;
        slip_ofs_i = '0;
    endtask

    task automatic expect_result(input string rq, input int k, input int fine);
        chk({rq, " coarse"}, coarse_o, k);
        chk({rq, " fine"}, fine_o, fine);
        chk({rq, " done early"}, done_o, 0);
        @(negedge clk);
        chk({rq, " R7 done"}, done_o, 1);
        chk({rq, " R5 delay"}, delay_ps_o, longint'(k) * 6400 + longint'(fine) * 320);
        @(negedge clk);
        chk({rq, " R7 done width"}, done_o, 0);
    endtask

    initial begin
        #(10 * 195000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 coarse in reset", coarse_o, 0);
        chk("R1 done in reset", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 delay", delay_ps_o, 0);
        chk("R1 timeout", timeout_o, 0);

        // R1 unarmed after reset: marker ignored
        send_marker(1, 3, 0, 0);
        @(negedge clk);
        chk("R1 R6 no done unarmed", done_o, 0);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            int f;
            f = VO[v] + ((VS[v] == 1) ? 10 : 0);
            pulse_start();
            send_marker(VK[v], VO[v], VS[v], VP[v]);
            expect_result((VS[v] == 2) ? "R3 both slots" : "R2 R4 vector", VK[v], f);
        end

        // R6 marker not armed: outputs hold
        send_marker(2, 9, 1, 0);
        repeat (2) @(negedge clk);
        chk("R6 unarmed done", done_o, 0);
        chk("R6 unarmed coarse hold", coarse_o, 2);
        chk("R6 unarmed fine hold", fine_o, 19);

        // R6 marker while unaligned is ignored, counting continues
        pulse_start();
        rx_aligned_i = 1'b0;
        send_marker(3, 4, 0, 0);
        rx_aligned_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 unaligned done", done_o, 0);
        chk("R7 start cleared coarse", coarse_o, 0);
        send_marker(2, 4, 0, 1);
        expect_result("R6 after unaligned", 7, 4);

        // R9 restart while armed
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        send_marker(6, 2, 1, 1);
        expect_result("R9 restart", 6, 12);

        // R8 timeout
        pulse_start();
        repeat (131070) @(negedge clk);
        chk("R8 timeout before sat", timeout_o, 0);
        @(negedge clk);
        chk("R8 timeout", timeout_o, 1);
        send_marker(1, 1, 0, 0);
        @(negedge clk);
        chk("R8 no done after timeout", done_o, 0);
        chk("R8 coarse zero", coarse_o, 0);
        pulse_start();
        chk("R8 timeout cleared", timeout_o, 0);
        send_marker(1, 0, 0, 0);
        expect_result("R8 after clear", 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule